// File: doc/BRIEF.md
# Serial SAR ADC Frame Reader

This block sits on the host side of a 16-bit successive-approximation ADC that has a three-wire serial port: an active-low select, a serial clock and a data line from the converter. A single start request produces one frame. The block drops the select, derives the serial clock from the system clock through a fixed divider, and counts falling edges of that clock. It skips the edges during which the converter is still busy. It then checks the marker bit that the converter forces low and shifts in the result word, most significant bit first.

When the frame ends, the select returns high half a serial period after the last falling edge. At the same time the word and a framing-error flag are registered, and a single-cycle valid strobe marks them. A minimum spacing between the starts of frames is enforced so that the converter's throughput limit holds. A request that arrives during a frame, or during the spacing that follows it, is remembered and served as soon as the spacing allows. The divider, the frame length, the minimum cycle and the word width are parameters. Elaboration rejects a frame that is too short to carry marker and data, and rejects a cycle that is shorter than one frame.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While the synchronous reset is active and after it releases, `cs_n_o` is 1 and `sclk_o`, `valid_o`, `frame_err_o` and `busy_o` are 0.
- R2: A `start_i` sampled high while idle drives `cs_n_o` low and `busy_o` high at the next clock edge. Every level of `sclk_o` in the frame, the first low level included, lasts exactly `DIV_HALF` system cycles.
- R3: A frame contains exactly `FRAME_CLKS` rising edges of `sclk_o`. `FRAME_CLKS` must be at least `LEAD_FALLS + 1 + DW` (22 with the defaults).
- R4: The data line is sampled at each falling edge of `sclk_o`. The sample at falling edge number `LEAD_FALLS + 1` (the 6th) is the marker. `frame_err_o` equals that sample: 1 marks a framing error.
- R5: The samples at falling edges `LEAD_FALLS + 2` through `LEAD_FALLS + 1 + DW` (the 7th to the 22nd) form `data_o`, first sample in bit 15, as plain unsigned binary.
- R6: The data line has no effect on the result while `cs_n_o` is high, before the marker edge, or at falling edges after the last data edge.
- R7: `cs_n_o` rises exactly `DIV_HALF` cycles after the last falling edge of `sclk_o`. `valid_o` is high for that one cycle only, with `data_o` and `frame_err_o` already updated.
- R8: Falling edges of `cs_n_o` are at least `MIN_CYCLE` system cycles apart. A start request that arrives while `busy_o` is high is kept, and its frame begins exactly `MIN_CYCLE` cycles after the previous falling edge of `cs_n_o`.
- R9: `sclk_o` is low whenever `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request for one conversion frame |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | DW | Last result word |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Marker bit of the last frame was not 0 |
| busy_o | output | 1 | Frame or minimum cycle in progress |

## Verification
On every cycle the checker confirms the following: the serial clock stays low outside a frame; the select rise and the valid strobe coincide; the strobe lasts one cycle; an idle start drops the select; each frame carries the full count of serial clock edges; and select falls are spaced by the minimum cycle. The bench models the converter's serial output. Only its scenarios can show that the word lands in the right bit order, that the marker sets or clears the error flag, and that junk on the line after the last data bit or outside a frame is ignored. They also show the exact half-period and tail timing, and that a queued request is served at exactly the minimum spacing.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2,
      ST_GAP  = 2'd3
   } rd_state_t;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
   parameter int DIV_HALF = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic count_en,
   input  logic toggle_en,
   output logic half_tick,
   output logic fall_tick,
   output logic sclk
);

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign half_tick = count_en;
      end else begin : g_div
         localparam int HW = $clog2(DIV_HALF);
         logic [HW-1:0] hcnt;
         always_ff @(posedge clk) begin
            if (rst || !count_en)
               hcnt <= '0;
            else if (hcnt == HW'(DIV_HALF - 1))
               hcnt <= '0;
            else
               hcnt <= hcnt + HW'(1);
         end
         assign half_tick = count_en && (hcnt == HW'(DIV_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         sclk <= 1'b0;
      else if (toggle_en && half_tick)
         sclk <= ~sclk;
   end

   assign fall_tick = toggle_en && half_tick && sclk;

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
   parameter int DW         = 16,
   parameter int LEAD_FALLS = 5,
   parameter int FRAME_CLKS = 24
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic          fall_tick,
   input  logic          sdi,
   output logic [DW-1:0] word,
   output logic          marker,
   output logic          last_fall
);

   localparam int CW       = $clog2(FRAME_CLKS + 1);
   localparam int MARK_NUM = LEAD_FALLS + 1;
   localparam int LAST_NUM = LEAD_FALLS + 1 + DW;

   logic [CW-1:0] fcnt;
   int            fnum;

   assign fnum      = int'(fcnt) + 1;
   assign last_fall = fall_tick && (fcnt == CW'(FRAME_CLKS - 1));

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         fcnt   <= '0;
         word   <= '0;
         marker <= 1'b0;
      end else if (fall_tick) begin
         fcnt <= fcnt + CW'(1);
         if (fnum == MARK_NUM)
            marker <= sdi;
         else if (fnum > MARK_NUM && fnum <= LAST_NUM)
            word <= {word[DW-2:0], sdi};
      end
   end

endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
   parameter int MIN_CYCLE = 500
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   output logic done
);

   localparam int TW = $clog2(MIN_CYCLE + 1);

   logic [TW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (rst || clear)
         tcnt <= '0;
      else if (tcnt != TW'(MIN_CYCLE))
         tcnt <= tcnt + TW'(1);
   end

   assign done = (tcnt >= TW'(MIN_CYCLE - 2));

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
   parameter int DIV_HALF   = 9,
   parameter int FRAME_CLKS = 24,
   parameter int MIN_CYCLE  = 500,
   parameter int DW         = 16,
   parameter int LEAD_FALLS = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          sdi_i,
   output logic          cs_n_o,
   output logic          sclk_o,
   output logic [DW-1:0] data_o,
   output logic          valid_o,
   output logic          frame_err_o,
   output logic          busy_o
);
   import adc_rd_pkg::*;

   localparam int MIN_FRAME = LEAD_FALLS + 1 + DW;
   localparam int FRAME_CYC = 2 * DIV_HALF * FRAME_CLKS + DIV_HALF + 2;

   generate
      if (FRAME_CLKS < MIN_FRAME) begin : g_bad_frame
         $error("FRAME_CLKS too small for marker and data");
      end
      if (MIN_CYCLE < FRAME_CYC) begin : g_bad_cycle
         $error("MIN_CYCLE shorter than one frame");
      end
      if (DIV_HALF < 1 || DW < 2) begin : g_bad_div
         $error("DIV_HALF and DW out of range");
      end
   endgenerate

   rd_state_t     state;
   logic          pend;
   logic          accept;
   logic          half_tick, fall_tick, last_fall;
   logic          gap_done;
   logic [DW-1:0] word;
   logic          marker;
   logic          tail_end;

   assign accept   = (state == ST_IDLE) && (start_i || pend);
   assign tail_end = (state == ST_TAIL) && half_tick;
   assign busy_o   = (state != ST_IDLE);

   adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
      .clk       (clk),
      .rst       (rst),
      .count_en  ((state == ST_RUN) || (state == ST_TAIL)),
      .toggle_en (state == ST_RUN),
      .half_tick (half_tick),
      .fall_tick (fall_tick),
      .sclk      (sclk_o)
   );

   adc_rx_shift #(
      .DW         (DW),
      .LEAD_FALLS (LEAD_FALLS),
      .FRAME_CLKS (FRAME_CLKS)
   ) u_shift (
      .clk       (clk),
      .rst       (rst),
      .clear     (accept),
      .fall_tick (fall_tick),
      .sdi       (sdi_i),
      .word      (word),
      .marker    (marker),
      .last_fall (last_fall)
   );

   adc_cycle_timer #(.MIN_CYCLE(MIN_CYCLE)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clear (accept),
      .done  (gap_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: if (accept)    state <= ST_RUN;
            ST_RUN:  if (last_fall) state <= ST_TAIL;
            ST_TAIL: if (half_tick) state <= ST_GAP;
            ST_GAP:  if (gap_done)  state <= ST_IDLE;
            default:                state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         pend <= 1'b0;
      else if (accept)
         pend <= 1'b0;
      else if (start_i && state != ST_IDLE)
         pend <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_n_o      <= 1'b1;
         valid_o     <= 1'b0;
         data_o      <= '0;
         frame_err_o <= 1'b0;
      end else begin
         valid_o <= tail_end;
         if (accept)
            cs_n_o <= 1'b0;
         else if (tail_end)
            cs_n_o <= 1'b1;
         if (tail_end) begin
            data_o      <= word;
            frame_err_o <= marker;
         end
      end
   end

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
   parameter int FRAME_CLKS = 24,
   parameter int MIN_CYCLE  = 500
) (
   input logic clk,
   input logic rst,
   input logic start_i,
   input logic cs_n_o,
   input logic sclk_o,
   input logic valid_o,
   input logic busy_o
);

   localparam int TW = $clog2(MIN_CYCLE + 1);
   localparam int RW = $clog2(FRAME_CLKS + 2);

   logic [TW-1:0] since_fall;
   logic [RW-1:0] rise_cnt;
   logic          cs_q, sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_fall <= TW'(MIN_CYCLE);
         rise_cnt   <= '0;
         cs_q       <= 1'b1;
         sclk_q     <= 1'b0;
      end else begin
         cs_q   <= cs_n_o;
         sclk_q <= sclk_o;
         if (cs_q && !cs_n_o)
            since_fall <= TW'(1);
         else if (since_fall != TW'(MIN_CYCLE))
            since_fall <= since_fall + TW'(1);
         if (cs_n_o)
            rise_cnt <= '0;
         else if (sclk_o && !sclk_q && rise_cnt != RW'(FRAME_CLKS + 1))
            rise_cnt <= rise_cnt + RW'(1);
      end
   end

   p_sclk_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
      cs_n_o |-> !sclk_o);

   p_start_drops_cs_r2: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> !cs_n_o);

   p_busy_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
      !cs_n_o |-> busy_o);

   p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   p_valid_at_cs_rise_r7: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (cs_n_o && !cs_q));

   p_cs_rise_valid_r7: assert property (@(posedge clk) disable iff (rst)
      (cs_n_o && !cs_q) |-> valid_o);

   p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
      (cs_n_o && !cs_q) |-> (rise_cnt == RW'(FRAME_CLKS)));

   p_min_spacing_r8: assert property (@(posedge clk) disable iff (rst)
      (!cs_n_o && cs_q) |-> (since_fall >= TW'(MIN_CYCLE)));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
   .FRAME_CLKS (FRAME_CLKS),
   .MIN_CYCLE  (MIN_CYCLE)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .cs_n_o  (cs_n_o),
   .sclk_o  (sclk_o),
   .valid_o (valid_o),
   .busy_o  (busy_o)
);

// File: tb/adc_rd_ctrl_test.sv
module adc_rd_ctrl_test;

   localparam int DIV  = 9;
   localparam int FRM  = 24;
   localparam int MINC = 500;
   localparam int DW   = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          sdi;
   logic          cs_n, sclk, valid, ferr, busy;
   logic [DW-1:0] data;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   adc_rd_ctrl #(
      .DIV_HALF   (DIV),
      .FRAME_CLKS (FRM),
      .MIN_CYCLE  (MINC),
      .DW         (DW),
      .LEAD_FALLS (5)
   ) uut (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start),
      .sdi_i       (sdi),
      .cs_n_o      (cs_n),
      .sclk_o      (sclk),
      .data_o      (data),
      .valid_o     (valid),
      .frame_err_o (ferr),
      .busy_o      (busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // converter model
   logic [DW-1:0] m_word  = '0;
   logic          m_mark  = 1'b0;
   bit            m_junk  = 1'b0;
   logic          adc_bit = 1'b0;
   logic          idle_bit = 1'b0;
   int            nf = 0;

   function automatic logic model_bit(input int n, input logic [DW-1:0] w,
                                      input logic mk, input bit junk);
      if (n == 5)                 return mk;
      if (n >= 6 && n <= 21)      return w[21 - n];
      if (n > 21)                 return junk ? 1'($urandom) : 1'b0;
      return 1'($urandom);
   endfunction

   function automatic logic [DW-1:0] exp_word(input logic [DW-1:0] w);
      return w;
   endfunction

   function automatic logic exp_err(input logic mk);
      return mk;
   endfunction

   always @(negedge sclk or posedge cs_n) begin
      if (cs_n) nf = 0;
      else begin
         nf = nf + 1;
         adc_bit = model_bit(nf, m_word, m_mark, m_junk);
      end
   end

   always @(negedge clk) idle_bit <= 1'($urandom);
   assign sdi = cs_n ? idle_bit : adc_bit;

   // timing monitor
   int   cyc = 0;
   logic p_cs = 1'b1;
   logic p_sclk = 1'b0;
   int   t_sclk = 0, t_csf = 0, rises = 0, last_gap = 0;
   bit   seen_fall = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (p_cs && !cs_n) begin
            if (seen_fall) begin
               last_gap = cyc - t_csf;
               check(last_gap >= MINC, "R8", "cs fall spacing", last_gap, MINC);
            end
            seen_fall = 1;
            t_csf  = cyc;
            t_sclk = cyc;
            rises  = 0;
         end
         if (sclk != p_sclk) begin
            check(cyc - t_sclk == DIV, "R2", "sclk level length", cyc - t_sclk, DIV);
            t_sclk = cyc;
            if (sclk) rises++;
         end
         if (!p_cs && cs_n) begin
            check(cyc - t_sclk == DIV, "R7", "cs rise delay", cyc - t_sclk, DIV);
            check(rises == FRM, "R3", "sclk rises per frame", rises, FRM);
            check(sclk == 1'b0, "R9", "sclk low with cs high", int'(sclk), 0);
         end
      end
      p_cs   = cs_n;
      p_sclk = sclk;
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_result(input logic [DW-1:0] w, input logic mk);
      while (!valid) @(negedge clk);
      check(data == exp_word(w), "R5", "result word", int'(data), int'(exp_word(w)));
      check(ferr == exp_err(mk), "R4", "frame error flag", int'(ferr), int'(exp_err(mk)));
      check(cs_n == 1'b1, "R7", "cs high with valid", int'(cs_n), 1);
      @(negedge clk);
      check(valid == 1'b0, "R7", "valid one cycle", int'(valid), 0);
   endtask

   task automatic run_frame(input logic [DW-1:0] w, input logic mk, input bit junk);
      m_word = w; m_mark = mk; m_junk = junk;
      pulse_start();
      check(cs_n == 1'b0 && busy == 1'b1, "R2", "cs low and busy after start",
            int'({cs_n, busy}), 1);
      wait_result(w, mk);
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n == 1'b1, "R1", "reset cs_n", int'(cs_n), 1);
      check({sclk, valid, ferr, busy} == 4'b0, "R1", "reset outputs",
            int'({sclk, valid, ferr, busy}), 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check(cs_n == 1'b1 && busy == 1'b0 && data == '0, "R1", "idle after reset",
            int'({cs_n, busy}), 2);

      // directed corners
      run_frame(16'h0000, 1'b0, 1'b1);
      run_frame(16'hFFFF, 1'b0, 1'b1);
      run_frame(16'h8000, 1'b0, 1'b1);
      run_frame(16'h0001, 1'b0, 1'b1);    // R6: junk after LSB discarded
      run_frame(16'hA5C3, 1'b1, 1'b0);    // R4: bad marker
      run_frame(16'h5A3C, 1'b0, 1'b0);    // R4: error flag cleared again

      // R6: long idle with random line, result unchanged
      repeat (200) @(negedge clk);
      check(data == 16'h5A3C && valid == 1'b0, "R6", "idle line ignored",
            int'(data), 16'h5A3C);

      // constrained random
      for (int i = 0; i < 10; i++) begin
         logic [DW-1:0] w;
         logic mk;
         w  = DW'($urandom);
         mk = ($urandom % 4 == 0);
         run_frame(w, mk, 1'b1);
      end

      // R8: request during busy is held and served at the minimum spacing
      m_word = 16'h1234; m_mark = 1'b0; m_junk = 1'b1;
      pulse_start();
      repeat (100) @(negedge clk);
      pulse_start();
      wait_result(16'h1234, 1'b0);
      while (!(p_cs && !cs_n) && busy) @(negedge clk);
      while (cs_n) @(negedge clk);
      @(negedge clk);
      check(last_gap == MINC, "R8", "held request spacing", last_gap, MINC);
      wait_result(16'h1234, 1'b0);
      while (busy) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule